// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a receive MAC. It takes each incoming frame as a byte stream with start and end markers and writes it into a ring of software-owned buffers in a simple synchronous memory. Every buffer holds 128 bytes and is described by an 8-byte descriptor. The first descriptor word holds the buffer address and two control bits. The second word holds fragment flags and, on the final fragment, the frame length. Frames longer than one buffer are spread over consecutive descriptors.

Before the block writes into a buffer, it reads the descriptor and checks the ownership bit. When a buffer is full, or the frame ends, it writes the status word and then sets the ownership bit to hand the buffer back to software. It reports each stored frame with a one-cycle completion pulse. It reports every descriptor it finds still owned by software with a one-cycle no-buffer pulse. While reception is disabled, the ring base is reloaded from the configuration input and incoming bytes are thrown away.

Top module: `rxring_writer`

## Requirements
- R1: After reset, `mem_req`, `rx_done` and `rx_nobuf` are low. With `rx_enable` low, `in_ready` is high.
- R2: Descriptor i lies at the ring base plus 8*i, and bits [2:0] of `ring_base` are ignored. In word 0, bit 0 is the ownership ("used") bit, bit 1 is the wrap bit, and bits [31:2] give the word-aligned buffer address with bits [1:0] taken as zero.
- R3: A descriptor whose used bit is set when it is fetched is never written and neither is its buffer. If this happens at the start of a frame, the whole frame is consumed and discarded, `rx_nobuf` pulses, and the next frame fetches the same descriptor again.
- R4: Frame byte k of a fragment goes to the buffer address plus (k & ~3), in bits [8*(k%4)+7 : 8*(k%4)] of the 32-bit word (little-endian). A final partial word is written with its unused bytes zero, and no word past the last data word is written.
- R5: Each buffer receives exactly 128 bytes before the frame continues in the next descriptor.
- R6: Word 1 is written as follows: bit 14 is set only on the first fragment of a frame, bit 15 only on the last fragment, and bits [11:0] hold the total frame length on the last fragment. All other bits are zero.
- R7: After word 1 of a fragment is written, word 0 is rewritten with the used bit set and the address and wrap bit unchanged.
- R8: After a descriptor whose wrap bit is set, the next descriptor is fetched from the ring base. Otherwise the next descriptor is the one 8 bytes higher.
- R9: `rx_done` pulses exactly once for each frame that is stored completely. The pulse comes in the cycle after the final hand-back write.
- R10: If the next descriptor is still owned by software in the middle of a frame, `rx_nobuf` pulses and the rest of the frame is consumed without any memory access. Fragments already handed back keep no end-of-frame bit, and the next frame starts at the refused descriptor.
- R11: While `rx_enable` is low and no frame is in progress, all stream bytes are accepted and dropped, no memory request is made, and the descriptor pointer is reloaded from `ring_base`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception enable; when low the ring base is reloaded |
| ring_base | input | 32 | Byte address of descriptor 0 |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high together with in_valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_done | output | 1 | One-cycle pulse per completely stored frame |
| rx_nobuf | output | 1 | One-cycle pulse when a fetched descriptor is still owned by software |

## Verification
A wrong descriptor pointer shows up within one frame: the data lands in the wrong buffer, or a descriptor after the wrap stays untouched while one past the ring end is written. A packing or byte-count error shows as a wrong word in the buffer, a missing zero pad, or a sentinel overwritten past the frame's end, all visible as soon as the frame closes. An ownership or drop error shows as a changed sentinel in a refused buffer, a missing `rx_nobuf` pulse, or a next frame placed at the wrong descriptor. Sweeping frame lengths around one, two, three and four buffer sizes on a four-descriptor ring drives every fragment boundary and the wrap.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int WORD_W     = 32;
  localparam int OWN_BIT    = 0;
  localparam int WRAP_BIT   = 1;
  localparam int SOF_BIT    = 14;
  localparam int EOF_BIT    = 15;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_FILL,
    ST_CLOSE1,
    ST_CLOSE0,
    ST_SKIP
  } wr_state_t;

  // descriptors start on an 8-byte boundary
  function automatic logic [31:0] ring_align(input logic [31:0] a);
    return {a[31:3], 3'b000};
  endfunction

  // low two bits of word 0 hold flags, not address
  function automatic logic [31:0] buf_base(input logic [31:0] w0);
    return {w0[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] fill_addr(input logic [31:0] w0,
                                            input logic [31:0] cnt);
    return buf_base(w0) + {cnt[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic        wrap);
    return wrap ? base : cur + 32'(DESC_BYTES);
  endfunction

  function automatic logic [31:0] status_word(input logic        first,
                                              input logic        last,
                                              input logic [13:0] len);
    logic [31:0] r;
    r = '0;
    r[SOF_BIT] = first;
    r[EOF_BIT] = last;
    if (last) r[13:0] = len;
    return r;
  endfunction
endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] base_in,
  input  logic        step,
  input  logic        wrap,
  output logic [31:0] ptr
);
  logic [31:0] base_q;
  logic [31:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (load) begin
      base_q <= ring_align(base_in);
      ptr_q  <= ring_align(base_in);
    end else if (step) begin
      ptr_q <= next_desc(ptr_q, base_q, wrap);
    end
  end

  assign ptr = ptr_q;

  // R8
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap && !load) |=> (ptr == base_q));

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap && !load) |=> (ptr - $past(ptr) == 32'(DESC_BYTES)));
endmodule

// File: rtl/rxring_packer.sv
module rxring_packer
  import rxring_pkg::*;
#(
  parameter int LANES = WORD_W / 8,
  localparam int LW   = $clog2(LANES)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 flush,
  input  logic [LW-1:0]        lane,
  input  logic [7:0]           din,
  output logic [8*LANES-1:0]   word
);
  logic [8*LANES-1:0] held;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] hold_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hold_r <= '0;
      else if (take)
        hold_r <= flush ? 8'h00 : ((lane == LW'(g)) ? din : hold_r);
    end
    assign held[8*g +: 8] = hold_r;
    assign word[8*g +: 8] = (lane == LW'(g)) ? din : hold_r;
  end

  // R4
  pad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && flush) |=> (held == '0));
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12,
  localparam int CNT_W    = $clog2(BUF_BYTES)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_enable,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  output logic        take,
  output logic        flush,
  output logic [1:0]  lane,
  input  logic [31:0] packed_word,
  input  logic [31:0] desc_ptr,
  output logic        ptr_load,
  output logic        ptr_step,
  output logic        ptr_wrap,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rx_done,
  output logic        rx_nobuf
);
  wr_state_t        st, st_n;
  logic [31:0]      w0_q;
  logic [CNT_W-1:0] fill_cnt;
  logic [LEN_W-1:0] frame_len;
  logic             first_q, last_q, own_q;
  logic             done_q, nobuf_q;

  // named internal events
  logic accept, buf_full, ev_word_wr, ev_refused, ev_granted, ev_handback, ev_start;

  assign accept      = in_valid && in_ready;
  assign buf_full    = (fill_cnt == CNT_W'(BUF_BYTES - 1));
  assign lane        = fill_cnt[1:0];
  assign flush       = (lane == 2'd3) || in_eof || buf_full;
  assign take        = (st == ST_FILL) && accept;
  assign ev_word_wr  = take && flush;
  assign ev_refused  = (st == ST_CHECK) && mem_rdata[OWN_BIT];
  assign ev_granted  = (st == ST_CHECK) && !mem_rdata[OWN_BIT];
  assign ev_handback = (st == ST_CLOSE0);
  assign ev_start    = (st == ST_IDLE) && rx_enable && in_valid && in_sof;

  assign ptr_load = (st == ST_IDLE) && !rx_enable;
  assign ptr_step = ev_handback;
  assign ptr_wrap = w0_q[WRAP_BIT];

  always_comb begin
    case (st)
      ST_IDLE:          in_ready = !rx_enable || !(in_valid && in_sof);
      ST_FILL, ST_SKIP: in_ready = 1'b1;
      default:          in_ready = 1'b0;
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:   if (ev_start) st_n = ST_FETCH;
      ST_FETCH:  st_n = ST_CHECK;
      ST_CHECK:  st_n = mem_rdata[OWN_BIT] ? ST_SKIP : ST_FILL;
      ST_FILL:   if (take && (in_eof || buf_full)) st_n = ST_CLOSE1;
      ST_CLOSE1: st_n = ST_CLOSE0;
      ST_CLOSE0: st_n = last_q ? ST_IDLE : ST_FETCH;
      ST_SKIP:   if (accept && in_eof) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    case (st)
      ST_FETCH: mem_req = 1'b1;
      ST_FILL: begin
        mem_req   = ev_word_wr;
        mem_we    = ev_word_wr;
        mem_addr  = fill_addr(w0_q, 32'(fill_cnt));
        mem_wdata = packed_word;
      end
      ST_CLOSE1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + 32'd4;
        mem_wdata = status_word(first_q, last_q, 14'(frame_len));
      end
      ST_CLOSE0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = w0_q | 32'h1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      w0_q      <= '0;
      fill_cnt  <= '0;
      frame_len <= '0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      own_q     <= 1'b0;
      done_q    <= 1'b0;
      nobuf_q   <= 1'b0;
    end else begin
      st      <= st_n;
      done_q  <= ev_handback && last_q;
      nobuf_q <= ev_refused;
      if (ev_start) begin
        frame_len <= '0;
        first_q   <= 1'b1;
      end
      if (ev_granted) begin
        w0_q     <= mem_rdata;
        own_q    <= 1'b1;
        fill_cnt <= '0;
      end
      if (take) begin
        fill_cnt  <= fill_cnt + 1'b1;
        frame_len <= frame_len + LEN_W'(1);
        last_q    <= in_eof;
      end
      if (ev_handback) begin
        first_q <= 1'b0;
        own_q   <= 1'b0;
      end
    end
  end

  assign rx_done  = done_q;
  assign rx_nobuf = nobuf_q;

  // R3
  owned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_wr |-> own_q);

  // R5
  buffer_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_wr |-> ((mem_addr - buf_base(w0_q)) < 32'(BUF_BYTES)));

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ($past(mem_we) && !rx_nobuf));

  // R10
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !mem_req);

  // R6
  final_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_addr == desc_ptr + 32'd4) && mem_wdata[EOF_BIT])
      |-> (mem_wdata[LEN_W-1:0] != '0));

  // R1
  write_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_enable,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rx_done,
  output logic        rx_nobuf
);
  logic        take, flush;
  logic [1:0]  lane;
  logic [31:0] packed_word;
  logic [31:0] desc_ptr;
  logic        ptr_load, ptr_step, ptr_wrap;

  rxring_ctrl #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
    .take(take), .flush(flush), .lane(lane), .packed_word(packed_word),
    .desc_ptr(desc_ptr), .ptr_load(ptr_load), .ptr_step(ptr_step), .ptr_wrap(ptr_wrap),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .rx_nobuf(rx_nobuf)
  );

  rxring_packer #(.LANES(WORD_W / 8)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush),
    .lane(lane), .din(in_data), .word(packed_word)
  );

  rxring_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .base_in(ring_base),
    .step(ptr_step), .wrap(ptr_wrap), .ptr(desc_ptr)
  );
endmodule

// File: tb/test_rxring_writer.sv
module test_rxring_writer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_enable = 0;
  logic [31:0] ring_base = 32'h100;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_data = 0;
  logic        in_sof = 0;
  logic        in_eof = 0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        rx_done, rx_nobuf;

  rxring_writer i_rxring_writer (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .rx_nobuf(rx_nobuf)
  );

  always #5 clk = ~clk;

  localparam logic [31:0] SENT = 32'hA5C3_0000;
  localparam int NDESC = 4;

  logic [31:0] mem [0:1023];
  logic        pk_en = 0;
  logic [9:0]  pk_a = 0;
  logic [31:0] pk_d = 0;

  always @(posedge clk) begin
    if (pk_en) mem[pk_a] <= pk_d;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, nobuf_cnt = 0, req_cnt = 0, cyc = 0;
  logic [31:0] base_al = 32'h100;

  always @(negedge clk) begin
    if (rst_n && rx_done) done_cnt++;
    if (rst_n && rx_nobuf) nobuf_cnt++;
  end
  always @(posedge clk) if (rst_n && mem_req) req_cnt++;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int fid, input int i);
    return 8'((fid * 29 + i * 7 + 3) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] bufa(input int d);
    return 32'h400 + 32'(128 * d);
  endfunction

  function automatic logic [31:0] wrapbit(input int d);
    return (d == NDESC - 1) ? 32'h2 : 32'h0;
  endfunction

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); pk_en = 1; pk_a = a[11:2]; pk_d = d;
    @(negedge clk); pk_en = 0;
  endtask

  task automatic reclaim();
    for (int d = 0; d < NDESC; d++) begin
      poke(base_al + 32'(8 * d), bufa(d) | wrapbit(d));
      poke(base_al + 32'(8 * d) + 4, 32'h0);
      for (int w = 0; w < 32; w++) poke(bufa(d) + 32'(4 * w), SENT ^ 32'(w));
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
    logic ok;
    ok = 0;
    @(negedge clk); in_valid = 1; in_data = b; in_sof = s; in_eof = e;
    while (!ok) begin
      #1 ok = in_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end
  endtask

  task automatic send_frame(input int fid, input int len);
    for (int i = 0; i < len; i++) send_byte(fb(fid, i), i == 0, i == len - 1);
    @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input int fid, input int len, input int first);
    logic [31:0] r;
    r = 0;
    for (int l = 0; l < 4; l++)
      if (first + l < len) r[8*l +: 8] = fb(fid, first + l);
    return r;
  endfunction

  // checks a fully stored frame beginning at descriptor p
  task automatic verify_frame(input int p, input int fid, input int len);
    int nf, d, n, nw;
    logic [31:0] e1;
    nf = (len + 127) / 128;
    for (int j = 0; j < nf; j++) begin
      d = (p + j) % NDESC;
      n = (len - 128 * j > 128) ? 128 : len - 128 * j;
      chk32("R7 handback word0", rdm(base_al + 32'(8 * d)), bufa(d) | wrapbit(d) | 32'h1);
      e1 = (j == 0) ? 32'h4000 : 32'h0;
      if (j == nf - 1) e1 = e1 | 32'h8000 | 32'(len);
      chk32("R6 status word1", rdm(base_al + 32'(8 * d) + 4), e1);
      nw = (n + 3) / 4;
      for (int k = 0; k < nw; k++)
        chk32(j == 0 ? "R4 data word" : "R5 continued data word",
              rdm(bufa(d) + 32'(4 * k)), exp_word(fid, len, 128 * j + 4 * k));
      if (nw < 32)
        chk32("R4 no write past end", rdm(bufa(d) + 32'(4 * nw)), SENT ^ 32'(nw));
    end
    if (nf < NDESC) begin
      d = (p + nf) % NDESC;
      chk32("R8 next descriptor untouched", rdm(base_al + 32'(8 * d)), bufa(d) | wrapbit(d));
    end
  endtask

  int lens [19] = '{1, 2, 3, 4, 5, 6, 7, 8, 126, 127, 128, 129, 130, 255, 256, 257, 384, 512, 300};

  initial begin
    int idx, d0, n0, r0, fid;
    idx = 0; fid = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk32("R1 mem_req", 32'(mem_req), 0);
    chk32("R1 rx_done", 32'(rx_done), 0);
    chk32("R1 rx_nobuf", 32'(rx_nobuf), 0);
    #1 chk32("R1 in_ready", 32'(in_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11 disabled: bytes dropped, no memory access
    reclaim();
    r0 = req_cnt; d0 = done_cnt;
    send_frame(fid++, 10);
    chk32("R11 no memory access while disabled", 32'(req_cnt - r0), 0);
    chk32("R11 no completion while disabled", 32'(done_cnt - d0), 0);
    chk32("R11 buffer untouched", rdm(bufa(0)), SENT);

    rx_enable = 1;
    @(negedge clk);

    // length sweep over fragment boundaries and the wrap
    foreach (lens[t]) begin
      reclaim();
      d0 = done_cnt; n0 = nobuf_cnt;
      send_frame(fid, lens[t]);
      verify_frame(idx, fid, lens[t]);
      chk32("R9 one done pulse", 32'(done_cnt - d0), 1);
      chk32("R3 no refusal", 32'(nobuf_cnt - n0), 0);
      idx = (idx + (lens[t] + 127) / 128) % NDESC;
      fid++;
    end

    // R3 descriptor owned by software at frame start
    reclaim();
    poke(base_al + 32'(8 * idx), bufa(idx) | wrapbit(idx) | 32'h1);
    d0 = done_cnt; n0 = nobuf_cnt;
    send_frame(fid++, 40);
    chk32("R3 nobuf pulse", 32'(nobuf_cnt - n0), 1);
    chk32("R3 no completion", 32'(done_cnt - d0), 0);
    chk32("R3 buffer untouched", rdm(bufa(idx)), SENT);
    chk32("R3 word1 untouched", rdm(base_al + 32'(8 * idx) + 4), 0);
    reclaim();
    send_frame(fid, 20);
    verify_frame(idx, fid, 20);
    idx = (idx + 1) % NDESC; fid++;

    // R10 descriptor owned by software in mid-frame
    reclaim();
    poke(base_al + 32'(8 * ((idx + 1) % NDESC)),
         bufa((idx + 1) % NDESC) | wrapbit((idx + 1) % NDESC) | 32'h1);
    d0 = done_cnt; n0 = nobuf_cnt;
    send_frame(fid, 200);
    chk32("R10 first fragment handed back", rdm(base_al + 32'(8 * idx)),
          bufa(idx) | wrapbit(idx) | 32'h1);
    chk32("R10 first fragment has no end flag", rdm(base_al + 32'(8 * idx) + 4), 32'h4000);
    for (int k = 0; k < 32; k++)
      chk32("R10 first fragment data", rdm(bufa(idx) + 32'(4 * k)), exp_word(fid, 200, 4 * k));
    chk32("R10 refused word1 untouched", rdm(base_al + 32'(8 * ((idx + 1) % NDESC)) + 4), 0);
    chk32("R10 refused buffer untouched", rdm(bufa((idx + 1) % NDESC)), SENT);
    chk32("R10 nobuf pulse", 32'(nobuf_cnt - n0), 1);
    chk32("R10 no completion", 32'(done_cnt - d0), 0);
    idx = (idx + 1) % NDESC; fid++;
    reclaim();
    send_frame(fid, 9);
    verify_frame(idx, fid, 9);
    idx = (idx + 1) % NDESC; fid++;

    // R11 reload of a new, unaligned base; R2 low bits ignored
    rx_enable = 0;
    ring_base = 32'h205;
    base_al = 32'h200;
    repeat (3) @(negedge clk);
    rx_enable = 1;
    idx = 0;
    reclaim();
    d0 = done_cnt;
    send_frame(fid, 130);
    verify_frame(idx, fid, 130);
    chk32("R2 reloaded base used", 32'(done_cnt - d0), 1);

    summary();
    $finish;
  end
endmodule